// File: doc/BRIEF.md
# Chained Conversion Readback Scheduler

This block runs one complete measurement pass over a daisy chain of battery-monitor converters. When started, it requests two command frames from an external serial shifter. The first points the chain's read pointer at the first cell result, addressed to every device. The second starts a conversion on all channels and selects full readback, again addressed to every device, with the averaging code placed in the command. The block then waits a settling interval. It computes that interval itself from the acquisition-time code, the averaging code and the number of extra devices in the chain. After the wait it reads one result frame per channel per device.

Each returned frame goes out on a one-cycle stream together with the CRC verdict of the external codec and a pair of threshold flags. Cell and auxiliary channels are compared against separate threshold pairs. The block also keeps a running total of the 12-bit results of the cell-voltage channels only. A frame whose CRC check fails ends the pass at once and raises an error indication.

Top module: `scanReadback`

## Requirements
- R1: After reset the block is idle: `busy`, `reqValid`, `frameValid`, `scanDone` and `scanErr` are 0 and `cellSum` is 0.
- R2: The first request after `start` is a write (`reqWrite`=1) to register 0x1C with value 0x00 and `reqAll`=1.
- R3: The second request is a write to register 0x0D with `reqAll`=1 and value 0x08 OR (averaging code shifted left by 1): input select and readback select both zero, and bit 3 starts the conversion on chip select.
- R4: The idle gap between the second write's completion and the first read request is CYC_PER_US × (ceil(D/1000) + 5) cycles. D = (tA + 695)·12·nA − tA + 250·E, where tA is 465/1010/1460/1890 for acquisition codes 0..3, nA is 1/2/4/8 for averaging codes 0..3, and E is the number of extra devices.
- R5: With no CRC error, exactly 12·(E+1) read requests are issued. `scanDone` then pulses for one cycle and `busy` falls on the next cycle.
- R6: For every completed read, `frameValid` is high in the following cycle, with `frameData` equal to the returned frame and `frameCrcOk` equal to the returned CRC status.
- R7: `cellSum` accumulates result bits 22:11 only for frames whose channel field (bits 26:23) is 5 or less and whose CRC is good. It is cleared at each start.
- R8: A read returned with a bad CRC is still streamed with `frameCrcOk`=0 and both flags 0. No further request follows, `scanDone` pulses in the same cycle as that frame, and `scanErr` stays 1 until the next start.
- R9: For a cell frame (channel ≤ 5) with good CRC, `frameRise` is set when the result is ≥ `cellHi`. Otherwise `frameFall` is set when the result is ≤ `cellLo`.
- R10: Auxiliary frames (channel > 5) use `auxHi`/`auxLo` under the same rise-before-fall rule.
- R11: A `start` pulse while `busy` is high has no effect: the read count and the sum of the running pass are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a pass (ignored while busy) |
| cfgAcq | input | 2 | Acquisition-time code |
| cfgAvg | input | 2 | Averaging code |
| cfgExtra | input | EXTRA_W | Number of devices beyond the first |
| cellHi | input | 12 | Cell high threshold |
| cellLo | input | 12 | Cell low threshold |
| auxHi | input | 12 | Auxiliary high threshold |
| auxLo | input | 12 | Auxiliary low threshold |
| reqValid | output | 1 | Frame request pending, held until `xferDone` |
| reqWrite | output | 1 | 1: command write, 0: result read |
| reqReg | output | 6 | Register address of a write |
| reqVal | output | 8 | Data byte of a write |
| reqAll | output | 1 | Write addressed to every device |
| xferDone | input | 1 | Shifter finished the pending request |
| rxFrame | input | 32 | Returned frame of a read |
| rxCrcOk | input | 1 | CRC verdict for `rxFrame` |
| frameValid | output | 1 | Streamed frame strobe |
| frameData | output | 32 | Streamed frame |
| frameCrcOk | output | 1 | CRC verdict of streamed frame |
| frameRise | output | 1 | Result at or above high threshold |
| frameFall | output | 1 | Result at or below low threshold, not rising |
| cellSum | output | SUM_W | Sum of good cell results in this pass |
| busy | output | 1 | Pass in progress |
| scanDone | output | 1 | One-cycle end-of-pass pulse |
| scanErr | output | 1 | Pass ended on a CRC failure |

## Verification
The checks assume that the shifter raises `xferDone` only while `reqValid` is high and for one cycle per request. They also assume that the configuration and thresholds stay steady through a pass. The bench's responder waits to see a pending request before it pulses `xferDone` for exactly one cycle. It changes configuration only between passes, so the streaming and abort properties see only legal handshakes. Wait lengths, frame counts, sums and flags are predicted from the formulas above for several chain lengths, code pairs, channel-address mixes and threshold boundary values.

// File: rtl/scanReadback_pkg.sv
package scanReadback_pkg;
  localparam int RES_W      = 12;
  localparam int FRAME_W    = 32;
  localparam int CH_PER_DEV = 12;
  localparam int CELL_LAST  = 5;
  localparam int CHAN_LSB   = 23;
  localparam int RES_LSB    = 11;
  localparam logic [5:0] REG_READ_PTR = 6'h1C;
  localparam logic [5:0] REG_CTRL_HI  = 6'h0D;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PTR, ST_CONV, ST_WAIT, ST_READ, ST_FIN
  } scanState_t;

  typedef struct packed {
    logic clear;
    logic capture;
  } dpStrobe_t;
endpackage

// File: rtl/scanReadback_ctrl.sv
module scanReadback_ctrl
  import scanReadback_pkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int EXTRA_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [1:0]         cfgAcq,
  input  logic [1:0]         cfgAvg,
  input  logic [EXTRA_W-1:0] cfgExtra,
  input  logic               xferDone,
  input  logic               rxCrcOk,
  output logic               reqValid,
  output logic               reqWrite,
  output logic [5:0]         reqReg,
  output logic [7:0]         reqVal,
  output logic               reqAll,
  output logic               busy,
  output logic               scanDone,
  output logic               scanErr,
  output dpStrobe_t          strobe
);
  localparam int CYC_PER_US = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int TICK_W     = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam int MAX_NS     = 2585 * CH_PER_DEV * 8 + 250 * (2 ** EXTRA_W) + 5000;
  localparam int NS_W       = $clog2(MAX_NS + 1);
  localparam int FRM_W      = $clog2(CH_PER_DEV * (2 ** EXTRA_W) + 1);

  scanState_t         state;
  logic [1:0]         acqL, avgL;
  logic [EXTRA_W-1:0] extraL;
  logic [NS_W-1:0]    remNs;
  logic [TICK_W-1:0]  tickCnt;
  logic [FRM_W-1:0]   frameCnt, lastIdx;

  // settling time in ns including the fixed 5 us margin
  function automatic logic [NS_W-1:0] waitNs(input logic [1:0] acq, input logic [1:0] avg,
                                             input logic [EXTRA_W-1:0] ext);
    logic [NS_W-1:0] tAcq, perPass;
    case (acq)
      2'd0:    tAcq = NS_W'(465);
      2'd1:    tAcq = NS_W'(1010);
      2'd2:    tAcq = NS_W'(1460);
      default: tAcq = NS_W'(1890);
    endcase
    perPass = (tAcq + NS_W'(695)) * NS_W'(CH_PER_DEV);
    return (perPass << avg) - tAcq + NS_W'(250) * NS_W'(ext) + NS_W'(5000);
  endfunction

  assign lastIdx = FRM_W'(CH_PER_DEV) * (FRM_W'(extraL) + FRM_W'(1)) - FRM_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      acqL     <= '0;
      avgL     <= '0;
      extraL   <= '0;
      remNs    <= '0;
      tickCnt  <= '0;
      frameCnt <= '0;
      scanErr  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          acqL    <= cfgAcq;
          avgL    <= cfgAvg;
          extraL  <= cfgExtra;
          scanErr <= 1'b0;
          state   <= ST_PTR;
        end
        ST_PTR: if (xferDone) state <= ST_CONV;
        ST_CONV: if (xferDone) begin
          remNs   <= waitNs(acqL, avgL, extraL);
          tickCnt <= '0;
          state   <= ST_WAIT;
        end
        ST_WAIT: begin
          if (tickCnt == TICK_W'(CYC_PER_US - 1)) begin
            tickCnt <= '0;
            if (remNs <= NS_W'(1000)) begin
              frameCnt <= '0;
              state    <= ST_READ;
            end else begin
              remNs <= remNs - NS_W'(1000);
            end
          end else begin
            tickCnt <= tickCnt + TICK_W'(1);
          end
        end
        ST_READ: if (xferDone) begin
          if (!rxCrcOk) begin
            scanErr <= 1'b1;
            state   <= ST_FIN;
          end else if (frameCnt == lastIdx) begin
            state <= ST_FIN;
          end else begin
            frameCnt <= frameCnt + FRM_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reqValid = 1'b0;
    reqWrite = 1'b0;
    reqReg   = '0;
    reqVal   = '0;
    reqAll   = 1'b0;
    case (state)
      ST_PTR: begin
        reqValid = 1'b1;
        reqWrite = 1'b1;
        reqReg   = REG_READ_PTR;
        reqAll   = 1'b1;
      end
      ST_CONV: begin
        reqValid = 1'b1;
        reqWrite = 1'b1;
        reqReg   = REG_CTRL_HI;
        reqVal   = {4'b0000, 1'b1, avgL, 1'b0};
        reqAll   = 1'b1;
      end
      ST_READ: reqValid = 1'b1;
      default: ;
    endcase
  end

  assign busy           = (state != ST_IDLE);
  assign scanDone       = (state == ST_FIN);
  assign strobe.clear   = (state == ST_IDLE) && start;
  assign strobe.capture = (state == ST_READ) && xferDone;
endmodule

// File: rtl/scanReadback_dp.sv
module scanReadback_dp
  import scanReadback_pkg::*;
#(
  parameter int SUM_W = 19
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [FRAME_W-1:0] rxFrame,
  input  logic               rxCrcOk,
  input  logic [RES_W-1:0]   cellHi,
  input  logic [RES_W-1:0]   cellLo,
  input  logic [RES_W-1:0]   auxHi,
  input  logic [RES_W-1:0]   auxLo,
  output logic               frameValid,
  output logic [FRAME_W-1:0] frameData,
  output logic               frameCrcOk,
  output logic               frameRise,
  output logic               frameFall,
  output logic [SUM_W-1:0]   cellSum
);
  logic [3:0]       chan;
  logic [RES_W-1:0] res, hiSel, loSel;
  logic             isCell, riseNow, fallNow;

  assign chan    = rxFrame[CHAN_LSB +: 4];
  assign res     = rxFrame[RES_LSB +: RES_W];
  assign isCell  = (chan <= 4'(CELL_LAST));
  assign hiSel   = isCell ? cellHi : auxHi;
  assign loSel   = isCell ? cellLo : auxLo;
  assign riseNow = rxCrcOk && (res >= hiSel);
  assign fallNow = rxCrcOk && !riseNow && (res <= loSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameValid <= 1'b0;
      frameData  <= '0;
      frameCrcOk <= 1'b0;
      frameRise  <= 1'b0;
      frameFall  <= 1'b0;
      cellSum    <= '0;
    end else begin
      frameValid <= strobe.capture;
      if (strobe.clear) cellSum <= '0;
      if (strobe.capture) begin
        frameData  <= rxFrame;
        frameCrcOk <= rxCrcOk;
        frameRise  <= riseNow;
        frameFall  <= fallNow;
        if (rxCrcOk && isCell) cellSum <= cellSum + SUM_W'(res);
      end
    end
  end
endmodule

// File: rtl/scanReadback.sv
module scanReadback
  import scanReadback_pkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int EXTRA_W = 3,
  localparam int SUM_W  = RES_W + $clog2(CH_PER_DEV * (2 ** EXTRA_W))
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [1:0]         cfgAcq,
  input  logic [1:0]         cfgAvg,
  input  logic [EXTRA_W-1:0] cfgExtra,
  input  logic [11:0]        cellHi,
  input  logic [11:0]        cellLo,
  input  logic [11:0]        auxHi,
  input  logic [11:0]        auxLo,
  output logic               reqValid,
  output logic               reqWrite,
  output logic [5:0]         reqReg,
  output logic [7:0]         reqVal,
  output logic               reqAll,
  input  logic               xferDone,
  input  logic [31:0]        rxFrame,
  input  logic               rxCrcOk,
  output logic               frameValid,
  output logic [31:0]        frameData,
  output logic               frameCrcOk,
  output logic               frameRise,
  output logic               frameFall,
  output logic [SUM_W-1:0]   cellSum,
  output logic               busy,
  output logic               scanDone,
  output logic               scanErr
);
  dpStrobe_t strobe;

  scanReadback_ctrl #(.CLK_HZ(CLK_HZ), .EXTRA_W(EXTRA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .cfgAcq(cfgAcq), .cfgAvg(cfgAvg),
    .cfgExtra(cfgExtra), .xferDone(xferDone), .rxCrcOk(rxCrcOk),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqReg(reqReg), .reqVal(reqVal),
    .reqAll(reqAll), .busy(busy), .scanDone(scanDone), .scanErr(scanErr),
    .strobe(strobe)
  );

  scanReadback_dp #(.SUM_W(SUM_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxFrame(rxFrame), .rxCrcOk(rxCrcOk),
    .cellHi(cellHi), .cellLo(cellLo), .auxHi(auxHi), .auxLo(auxLo),
    .frameValid(frameValid), .frameData(frameData), .frameCrcOk(frameCrcOk),
    .frameRise(frameRise), .frameFall(frameFall), .cellSum(cellSum)
  );
endmodule

// File: rtl/scanReadback_chk.sv
module scanReadback_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqWrite,
  input logic reqAll,
  input logic xferDone,
  input logic frameValid,
  input logic frameCrcOk,
  input logic frameRise,
  input logic frameFall,
  input logic busy,
  input logic scanDone
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !reqValid);
  p_write_all_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |-> reqAll);
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |=> (!scanDone && !busy));
  p_read_streams_r6: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && reqValid && !reqWrite) |=> frameValid);
  p_stream_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> $past(xferDone && reqValid && !reqWrite));
  p_bad_crc_flags_r8: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && !frameCrcOk) |-> (!frameRise && !frameFall));
  p_bad_crc_halt_r8: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && !frameCrcOk) |-> (scanDone && !reqValid));
  p_flag_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(frameRise && frameFall));
endmodule

bind scanReadback scanReadback_chk chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqAll(reqAll),
  .xferDone(xferDone), .frameValid(frameValid), .frameCrcOk(frameCrcOk),
  .frameRise(frameRise), .frameFall(frameFall), .busy(busy), .scanDone(scanDone)
);

// File: tb/scanReadback_tb.sv
module scanReadback_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TB_CLK_HZ  = 4_000_000;
  localparam int CYC_PER_US = 4;
  localparam int EXW        = 3;
  localparam int SUMW       = 19;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [1:0] cfgAcq = '0, cfgAvg = '0;
  logic [EXW-1:0] cfgExtra = '0;
  logic [11:0] cellHi = 12'hC00, cellLo = 12'h200, auxHi = 12'hE00, auxLo = 12'h100;
  logic reqValid, reqWrite, reqAll, frameValid, frameCrcOk, frameRise, frameFall;
  logic busy, scanDone, scanErr;
  logic [5:0] reqReg;
  logic [7:0] reqVal;
  logic xferDone = 1'b0, rxCrcOk = 1'b0;
  logic [31:0] rxFrame = '0, frameData;
  logic [SUMW-1:0] cellSum;
  int errCnt = 0, chkCnt = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  scanReadback #(.CLK_HZ(TB_CLK_HZ), .EXTRA_W(EXW)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .cfgAcq(cfgAcq), .cfgAvg(cfgAvg),
    .cfgExtra(cfgExtra), .cellHi(cellHi), .cellLo(cellLo), .auxHi(auxHi), .auxLo(auxLo),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqReg(reqReg), .reqVal(reqVal),
    .reqAll(reqAll), .xferDone(xferDone), .rxFrame(rxFrame), .rxCrcOk(rxCrcOk),
    .frameValid(frameValid), .frameData(frameData), .frameCrcOk(frameCrcOk),
    .frameRise(frameRise), .frameFall(frameFall), .cellSum(cellSum),
    .busy(busy), .scanDone(scanDone), .scanErr(scanErr)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int waitUs(input int acq, input int avg, input int ext);
    int tA, ns;
    tA = (acq == 0) ? 465 : (acq == 1) ? 1010 : (acq == 2) ? 1460 : 1890;
    ns = (tA + 695) * 12 * (1 << avg) - tA + 250 * ext;
    return (ns + 999) / 1000 + 5;
  endfunction

  function automatic int chanOf(input int i, input int mode);
    return (mode == 2) ? (i * 7) % 16 : i % 12;
  endfunction

  function automatic int resOf(input int i, input int mode);
    int ch, sel, hi, lo;
    ch = chanOf(i, mode);
    hi = (ch <= 5) ? int'(cellHi) : int'(auxHi);
    lo = (ch <= 5) ? int'(cellLo) : int'(auxLo);
    sel = (i / 2) % 4;
    if (mode == 1) return (sel == 0) ? hi : (sel == 1) ? lo : (sel == 2) ? hi - 1 : lo + 1;
    return (i * 331 + 17) % 4096;
  endfunction

  function automatic logic [31:0] mkFrame(input int i, input int mode);
    return {5'(i / 12), 4'(chanOf(i, mode)), 12'(resOf(i, mode)), 11'h2A5};
  endfunction

  task automatic runScan(input int acq, input int avg, input int ext, input int failIdx,
                         input int mode, input int restartAt, input string tag);
    int reads = 0, writes = 0, waitCyc = 0, dones = 0, expSum = 0, expReads, ch, rs, hi, lo;
    bit pend = 0, pendOk = 0, expR, expF;
    logic [31:0] fr = '0;
    expReads = (failIdx >= 0) ? failIdx + 1 : 12 * (ext + 1);
    cfgAcq = 2'(acq); cfgAvg = 2'(avg); cfgExtra = EXW'(ext);
    @(negedge clk); start = 1'b1;
    forever begin
      @(negedge clk);
      start = 1'b0; xferDone = 1'b0;
      if (pend) begin
        pend = 0;
        ch = chanOf(reads - 1, mode); rs = resOf(reads - 1, mode);
        hi = (ch <= 5) ? int'(cellHi) : int'(auxHi);
        lo = (ch <= 5) ? int'(cellLo) : int'(auxLo);
        expR = pendOk && (rs >= hi);
        expF = pendOk && !expR && (rs <= lo);
        chk(frameValid == 1'b1, {tag, " R6 frameValid"}, frameValid, 1);
        chk(frameData == fr, {tag, " R6 frameData"}, frameData, fr);
        chk(frameCrcOk == pendOk, {tag, " R6/R8 frameCrcOk"}, frameCrcOk, pendOk);
        chk(frameRise == expR, {tag, (ch <= 5) ? " R9 rise" : " R10 rise"}, frameRise, expR);
        chk(frameFall == expF, {tag, (ch <= 5) ? " R9 fall" : " R10 fall"}, frameFall, expF);
      end
      if (scanDone) begin
        dones++;
        chk(int'(cellSum) == expSum, {tag, " R7 cellSum"}, cellSum, expSum);
        chk(scanErr == (failIdx >= 0), {tag, " R8 scanErr"}, scanErr, failIdx >= 0);
      end
      if (!busy) break;
      if (reqValid && reqWrite) begin
        if (writes == 0) begin
          chk(reqReg == 6'h1C && reqVal == 8'h00 && reqAll, {tag, " R2 pointer write"},
              {reqAll, reqReg, reqVal}, {1'b1, 6'h1C, 8'h00});
        end else begin
          chk(reqReg == 6'h0D && reqVal == (8'h08 | 8'(avg << 1)) && reqAll,
              {tag, " R3 convert write"}, {reqAll, reqReg, reqVal},
              {1'b1, 6'h0D, 8'h08 | 8'(avg << 1)});
        end
        writes++;
        xferDone = 1'b1;
      end else if (reqValid) begin
        fr = mkFrame(reads, mode);
        pendOk = (reads != failIdx);
        rxFrame = fr; rxCrcOk = pendOk; xferDone = 1'b1;
        if (pendOk && chanOf(reads, mode) <= 5) expSum += resOf(reads, mode);
        if (reads == restartAt) start = 1'b1;
        reads++;
        pend = 1;
      end else if (writes == 2 && reads == 0) begin
        waitCyc++;
      end
    end
    chk(writes == 2, {tag, " R2/R3 write count"}, writes, 2);
    chk(waitCyc == CYC_PER_US * waitUs(acq, avg, ext), {tag, " R4 wait cycles"},
        waitCyc, CYC_PER_US * waitUs(acq, avg, ext));
    chk(reads == expReads, {tag, (restartAt >= 0) ? " R11 read count" : " R5 read count"},
        reads, expReads);
    chk(dones == 1, {tag, " R5 single done"}, dones, 1);
  endtask

  task automatic tReset();
    chk(!busy && !reqValid && !frameValid && !scanDone && !scanErr && cellSum == '0,
        "R1 reset state", {busy, reqValid, frameValid, scanDone, scanErr}, 0);
  endtask

  task automatic tBasic();      runScan(0, 0, 0, -1, 0, -1, "basic");     endtask
  task automatic tMidChain();   runScan(1, 2, 2, -1, 0, -1, "mid");       endtask
  task automatic tLongChain();  runScan(3, 3, 7, -1, 0, -1, "long");      endtask
  task automatic tCrcAbort();   runScan(2, 1, 1, 15, 0, -1, "crcAbort");  endtask
  task automatic tAfterAbort(); runScan(0, 1, 0, -1, 0, -1, "afterAbort"); endtask
  task automatic tAddrMix();    runScan(1, 0, 3, -1, 2, -1, "addrMix");   endtask
  task automatic tBusyStart();  runScan(0, 0, 1, -1, 0, 5, "busyStart");  endtask
  task automatic tBoundary();
    cellHi = 12'h800; cellLo = 12'h3FF; auxHi = 12'hA00; auxLo = 12'h050;
    runScan(0, 2, 1, -1, 1, -1, "boundary");
    cellHi = 12'hC00; cellLo = 12'h200; auxHi = 12'hE00; auxLo = 12'h100;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errCnt++; chkCnt++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBasic();
    tMidChain();
    tLongChain();
    tCrcAbort();
    tAfterAbort();
    tAddrMix();
    tBoundary();
    tBusyStart();
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule